// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

The block gathers 96 level-sensitive interrupt lines, split into three banks of 32, behind a plain 32-bit register port that takes a word-aligned byte address. Each bank has a mask word that software cannot write directly. Software changes the mask only by writing ones to a clear alias (which enables sources) or to a set alias (which disables them). A per-bank pending word shows the asserted sources with the masked ones removed.

When no interrupt is held and any enabled source is asserted, the controller latches the lowest-numbered one into an active-number register and raises a single request line to the processor. Both stay fixed until software writes an acknowledge to the control register. This also lets software drop a selection that went stale because its source was masked or deasserted while it was held. A configuration register holds an autoidle enable and a self-clearing soft-reset trigger, and a status register reports when that reset has completed. A read-only revision register identifies the block.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all mask words read 0xFFFFFFFF, irqReq is low, the active number (0x040) reads 0, configuration (0x010) reads 0 and status (0x014) reads 1.
- R2: Address 0x000 reads 0x00000040: bits 7:4 hold major version 4, bits 3:0 hold minor version 0.
- R3: For bank b (0 to 2), writing to 0x088 + 0x20*b clears every mask bit written as 1 and leaves the other bits unchanged. The mask word at 0x084 + 0x20*b is read-only, so writes to it have no effect.
- R4: Writing to 0x08C + 0x20*b sets every mask bit written as 1 and leaves the other bits unchanged. Both alias addresses read 0.
- R5: 0x098 + 0x20*b reads the asserted sources of bank b with the masked ones cleared. Bit i corresponds to source 32*b + i.
- R6: If no selection is held and any pending bit is set at a clock edge, that edge latches the lowest-numbered pending source into bits 6:0 of 0x040, and irqReq is high from that edge onward.
- R7: While a selection is held, the active number and irqReq stay unchanged, even if sources change or are masked.
- R8: Writing data with bit 0 set to 0x048 clears the selection at that edge, so irqReq drops. The next selection can come at the following edge. A write with bit 0 clear has no effect.
- R9: Writing configuration with bit 1 set starts a soft reset that lasts 4 cycles. During it, status bit 0 reads 0, configuration bit 1 reads 1, and register writes are ignored. At its end all sources are masked, the selection and active number clear, autoidle clears and bit 1 reads 0.
- R10: Configuration bit 0 (autoidle enable) reads back the last value written to it.
- R11: Unmapped addresses, including a fourth bank's window at 0x0E0 and above, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Word-aligned byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| srcIn | input | 96 | Level-sensitive interrupt sources |
| irqReq | output | 1 | Request to the processor while a selection is held |

## Verification
The bench goes after the hold-until-acknowledge rule. A design that reselected on every cycle would let the active number drift when a lower source arrives or the held source is masked. A design that took any write to the control register as an acknowledge would drop the request on a write with bit 0 clear. It checks the same-edge interplay of acknowledge and new selection, where a design that reselected in the acknowledge cycle would never let irqReq fall. It also checks the exact soft-reset window, where an off-by-one counter shows up as a status bit that returns one cycle early or late. Bank 1 and bank 2 registers at the 0x20 stride are covered as well, where a wrong stride decode would update the wrong bank's mask.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 12;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_REV  = 12'h000;
  localparam logic [ADDR_W-1:0] A_CFG  = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h014;
  localparam logic [ADDR_W-1:0] A_ACT  = 12'h040;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h048;
  localparam logic [ADDR_W-1:0] A_BANK = 12'h080;
  // offsets inside a bank window (stride 0x20)
  localparam logic [4:0] W_MASK = 5'h04;
  localparam logic [4:0] W_CLR  = 5'h08;
  localparam logic [4:0] W_SET  = 5'h0C;
  localparam logic [4:0] W_PEND = 5'h18;

  typedef enum logic [2:0] {
    RS_ZERO, RS_REV, RS_CFG, RS_STAT, RS_ACT, RS_MASK, RS_PEND
  } rdSel_e;

  typedef struct packed {
    logic       ack;
    logic       cfgWr;
    logic       busy;
    logic       doRst;
    logic       maskClr;
    logic       maskSet;
    logic [3:0] bank;
    rdSel_e     rdSel;
  } ctlStb_t;
endpackage

// File: rtl/birq_ctrl.sv
module birq_ctrl
  import birq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [1:0]        wrBits,
  output ctlStb_t           stb
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]  rstCnt;
  logic              busy;
  logic [ADDR_W-1:0] bankOff;
  logic [6:0]        bankIdx;
  logic [4:0]        bankWord;
  logic              inBank;
  logic              startRst;

  assign busy     = (rstCnt != '0);
  assign bankOff  = addr - A_BANK;
  assign bankIdx  = bankOff[ADDR_W-1:5];
  assign bankWord = bankOff[4:0];
  assign inBank   = (addr >= A_BANK) && (bankIdx < 7'(NUM_BANKS));
  assign startRst = wrEn && !busy && (addr == A_CFG) && wrBits[1];

  // soft-reset sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rstCnt <= '0;
    else if (startRst) rstCnt <= CNT_W'(RST_CYCLES);
    else if (busy)     rstCnt <= rstCnt - 1'b1;
  end

  always_comb begin
    stb       = '0;
    stb.busy  = busy;
    stb.doRst = (rstCnt == CNT_W'(1));
    stb.rdSel = RS_ZERO;
    case (addr)
      A_REV:  stb.rdSel = RS_REV;
      A_CFG:  begin stb.rdSel = RS_CFG; stb.cfgWr = wrEn && !busy; end
      A_STAT: stb.rdSel = RS_STAT;
      A_ACT:  stb.rdSel = RS_ACT;
      A_CTRL: stb.ack = wrEn && !busy && wrBits[0];
      default: begin
        if (inBank) begin
          stb.bank = bankIdx[3:0];
          case (bankWord)
            W_MASK:  stb.rdSel   = RS_MASK;
            W_CLR:   stb.maskClr = wrEn && !busy;
            W_SET:   stb.maskSet = wrEn && !busy;
            W_PEND:  stb.rdSel   = RS_PEND;
            default: ;
          endcase
        end
      end
    endcase
  end

  assert_rst_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    startRst |=> (busy && rstCnt == CNT_W'(RST_CYCLES)));
  assert_rst_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstCnt == CNT_W'(1)) |=> !busy);
  assert_rst_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstCnt <= CNT_W'(RST_CYCLES));
  assert_no_wr_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.ack || stb.cfgWr || stb.maskClr || stb.maskSet));
endmodule

// File: rtl/birq_datapath.sv
module birq_datapath
  import birq_pkg::*;
#(
  parameter int         NUM_BANKS = 3,
  parameter logic [7:0] REV_BYTE  = 8'h40
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStb_t                       stb,
  input  logic [31:0]                   wrData,
  input  logic [NUM_BANKS*BANK_W-1:0]   srcIn,
  output logic [31:0]                   rdData,
  output logic                          irqReq
);
  localparam int NSRC = NUM_BANKS * BANK_W;
  localparam int ID_W = $clog2(NSRC);

  logic [NUM_BANKS-1:0][BANK_W-1:0] maskQ;
  logic [NUM_BANKS-1:0][BANK_W-1:0] pendQ;
  logic [NSRC-1:0]                  pendFlat;
  logic [ID_W-1:0]                  actNum;
  logic [ID_W-1:0]                  lowId;
  logic                             selValid;
  logic                             autoIdle;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (stb.bank == 4'(b));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    maskQ[b] <= '1;
        else if (stb.doRst)           maskQ[b] <= '1;
        else if (stb.maskClr && hit)  maskQ[b] <= maskQ[b] & ~wrData;
        else if (stb.maskSet && hit)  maskQ[b] <= maskQ[b] | wrData;
      end
      assign pendQ[b] = srcIn[b*BANK_W +: BANK_W] & ~maskQ[b];
    end
  endgenerate

  assign pendFlat = pendQ;

  // lowest-numbered pending source wins
  always_comb begin
    lowId = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pendFlat[i]) lowId = ID_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selValid <= 1'b0;
      actNum   <= '0;
    end else if (stb.doRst) begin
      selValid <= 1'b0;
      actNum   <= '0;
    end else if (!stb.busy) begin
      if (stb.ack) begin
        selValid <= 1'b0;
      end else if (!selValid && (pendFlat != '0)) begin
        selValid <= 1'b1;
        actNum   <= lowId;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          autoIdle <= 1'b0;
    else if (stb.doRst) autoIdle <= 1'b0;
    else if (stb.cfgWr) autoIdle <= wrData[0];
  end

  assign irqReq = selValid;

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RS_REV:  rdData = 32'(REV_BYTE);
      RS_CFG:  rdData = {30'b0, stb.busy, autoIdle};
      RS_STAT: rdData = {31'b0, !stb.busy};
      RS_ACT:  rdData = 32'(actNum);
      RS_MASK: for (int b = 0; b < NUM_BANKS; b++)
                 if (stb.bank == 4'(b)) rdData = maskQ[b];
      RS_PEND: for (int b = 0; b < NUM_BANKS; b++)
                 if (stb.bank == 4'(b)) rdData = pendQ[b];
      default: rdData = '0;
    endcase
  end

  // assertion helper: sources numbered below the held one
  logic [NSRC-1:0] belowAct;
  assign belowAct = (NSRC'(1) << actNum) - NSRC'(1);

  assert_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(pendFlat[lowId]) || ($past(pendFlat) != '0));
  assert_lowest_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> (($past(pendFlat) & belowAct) == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !stb.ack && !stb.doRst) |=> (irqReq && $stable(actNum)));
  assert_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ack |=> !irqReq);
  assert_rst_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRst |=> ((&maskQ) && !irqReq && !autoIdle));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import birq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int REV_MAJOR  = 4,
  parameter int REV_MINOR  = 0,
  parameter int RST_CYCLES = 4,
  localparam int NSRC      = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [NSRC-1:0]   srcIn,
  output logic              irqReq
);
  localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

  ctlStb_t stb;

  birq_ctrl #(.NUM_BANKS(NUM_BANKS), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(busWrEn),
    .wrBits(busWrData[1:0]), .stb(stb)
  );

  birq_datapath #(.NUM_BANKS(NUM_BANKS), .REV_BYTE(REV_BYTE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .srcIn(srcIn), .rdData(busRdData), .irqReq(irqReq)
  );
endmodule

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;
  localparam int NB = 3;
  localparam int NS = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [NS-1:0] srcIn = '0;
  logic          irqReq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  banked_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .srcIn(srcIn), .irqReq(irqReq)
  );

  // ---- reference model built from the requirements ----
  logic [31:0] mM [NB];
  logic        selM;
  logic [6:0]  actM;
  logic        aiM;
  int          cntM;

  function automatic logic [NS-1:0] pendAll();
    logic [NS-1:0] p;
    for (int b = 0; b < NB; b++) p[b*32 +: 32] = srcIn[b*32 +: 32] & ~mM[b];
    return p;
  endfunction

  function automatic logic [31:0] expRd(input logic [11:0] a);
    int off;
    if (a == 12'h000) return 32'h40;
    if (a == 12'h010) return {30'b0, cntM != 0, aiM};
    if (a == 12'h014) return {31'b0, cntM == 0};
    if (a == 12'h040) return {25'b0, actM};
    if (a >= 12'h080) begin
      off = int'(a) - 'h80;
      if (off / 32 < NB) begin
        if (off % 32 == 'h04) return mM[off / 32];
        if (off % 32 == 'h18) return srcIn[(off/32)*32 +: 32] & ~mM[off / 32];
      end
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) mM[b] = '1;
      selM = 0; actM = 0; aiM = 0; cntM = 0;
    end else if (cntM != 0) begin
      cntM = cntM - 1;
      if (cntM == 0) begin
        for (int b = 0; b < NB; b++) mM[b] = '1;
        selM = 0; actM = 0; aiM = 0;
      end
    end else begin
      logic [NS-1:0] p;
      logic ackNow;
      int off;
      p = pendAll();
      ackNow = 0;
      if (busWrEn) begin
        if (busAddr == 12'h010) begin
          aiM = busWrData[0];
          if (busWrData[1]) cntM = 4;
        end else if (busAddr == 12'h048) begin
          ackNow = busWrData[0];
        end else if (busAddr >= 12'h080) begin
          off = int'(busAddr) - 'h80;
          if (off / 32 < NB) begin
            if (off % 32 == 'h08) mM[off/32] = mM[off/32] & ~busWrData;
            if (off % 32 == 'h0C) mM[off/32] = mM[off/32] | busWrData;
          end
        end
      end
      if (ackNow) selM = 0;
      else if (!selM && p != '0) begin
        selM = 1;
        for (int i = NS - 1; i >= 0; i--) if (p[i]) actM = 7'(i);
      end
    end
  end

  // ---- stimulus and checking ----
  task automatic report(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    busWrEn = 1'b0; busAddr = a;
    #1;
    report(tag, busRdData, expRd(a));
  endtask

  task automatic chkReq(input string tag);
    #1;
    report(tag, {31'b0, irqReq}, {31'b0, selM});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(12'h010, "R1 cfg");  report("R1 cfg const", busRdData, 32'h0);
    rd(12'h014, "R1 status"); report("R1 status const", busRdData, 32'h1);
    rd(12'h040, "R1 active");
    for (int b = 0; b < NB; b++) begin
      rd(12'(12'h084 + b * 32), "R1 mask");
      report("R1 mask const", busRdData, 32'hFFFF_FFFF);
    end
    chkReq("R1 irqReq low");
    // R2 revision
    rd(12'h000, "R2 revision"); report("R2 rev const", busRdData, 32'h40);
    // R11 unmapped
    rd(12'h020, "R11 unmapped"); rd(12'h0E4, "R11 fourth bank"); rd(12'h0F8, "R11 fourth pend");

    // R3 mask word read-only, clear alias
    wr(12'h0A4, 32'h0);
    rd(12'h0A4, "R3 mask ro"); report("R3 mask ro const", busRdData, 32'hFFFF_FFFF);
    wr(12'h0A8, 32'h0000_00F0);
    rd(12'h0A4, "R3 clr alias"); report("R3 clr const", busRdData, 32'hFFFF_FF0F);
    rd(12'h0A8, "R4 alias reads zero");

    // R5/R6: sources 37 (unmasked) and 70 (masked)
    @(negedge clk); srcIn[37] = 1'b1; srcIn[70] = 1'b1;
    rd(12'h0B8, "R5 pending bank1"); report("R5 pend const", busRdData, 32'h20);
    rd(12'h0D8, "R5 pending bank2 masked");
    idle(1);
    chkReq("R6 req up");
    rd(12'h040, "R6 active 37"); report("R6 act const", busRdData, 32'd37);

    // R7 hold while a lower source appears and the held one is masked
    wr(12'h088, 32'h8);
    @(negedge clk); srcIn[3] = 1'b1;
    wr(12'h0AC, 32'h20);
    idle(2);
    rd(12'h040, "R7 held"); report("R7 held const", busRdData, 32'd37);
    chkReq("R7 req held");

    // R8 ack with bit0 clear ignored, then real ack
    wr(12'h048, 32'h2);
    chkReq("R8 zero ack ignored");
    wr(12'h048, 32'h1);
    chkReq("R8 ack drops req"); report("R8 ack req const", {31'b0, irqReq}, 32'h0);
    idle(1);
    rd(12'h040, "R6 lowest after ack"); report("R6 lowest const", busRdData, 32'd3);

    // R4 set alias
    wr(12'h08C, 32'h8);
    rd(12'h084, "R4 set alias"); rd(12'h098, "R4 pend after set");

    // R10 autoidle
    wr(12'h010, 32'h1);
    rd(12'h010, "R10 autoidle"); report("R10 ai const", busRdData, 32'h1);

    // R9 soft reset window
    wr(12'h010, 32'h3);
    for (int k = 0; k < 4; k++) begin
      rd(12'h014, "R9 status busy"); report("R9 busy const", busRdData, 32'h0);
      rd(12'h010, "R9 cfg bit1");
      if (k == 1) wr(12'h0C8, 32'hFFFF_FFFF); else @(negedge clk);
      if (k == 1) k++;
    end
    rd(12'h014, "R9 status done"); report("R9 done const", busRdData, 32'h1);
    rd(12'h010, "R9 cfg cleared");
    rd(12'h0C4, "R9 masks set");
    chkReq("R9 req cleared");

    // randomized mix
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: begin @(negedge clk); srcIn[$urandom_range(0, NS-1)] ^= 1'b1; end
        1, 2: wr(12'(12'h088 + $urandom_range(0, NB-1) * 32), $urandom() & $urandom());
        3: wr(12'(12'h08C + $urandom_range(0, NB-1) * 32), $urandom() & $urandom() & $urandom());
        4: wr(12'h048, {$urandom()} & 32'h3);
        5: wr(12'h010, (it % 500 == 5) ? 32'h2 : ({$urandom()} & 32'h1));
        6: rd(12'(12'h084 + $urandom_range(0, NB-1) * 32 + ($urandom_range(0, 1) ? 'h14 : 0)), "R5 random mask/pend");
        7: rd(12'h040, "R6 random active");
        8: rd(12'(($urandom_range(0, 63)) * 4), "R11 random read");
        default: idle(1);
      endcase
      chkReq("R7 random req");
    end

    finishRun();
  end
endmodule